// File: doc/BRIEF.md
# Open-Page DRAM Controller with Row Refresh

This block sits between a processor-side word request port and an asynchronous-style DRAM that takes its row and column addresses over one shared bus. Each accepted request becomes a command sequence: the row address is presented and latched by the falling row strobe, and the column address follows and is latched by the falling column strobe. A write drives the data bus during the column phase. A read samples the DRAM output at the end of the column phase and returns it with a one-cycle response pulse.

After an access the row strobe stays low, so the row remains open as a page. A later request to that same row skips the row phase entirely and issues only a column strobe. A request to another row first closes the page with a timed precharge and then opens the new row.

A free-running interval counter raises a refresh request at a fixed period; the default is 1563 cycles, which is 15.625 us at 100 MHz. Each refresh strobes the next row in ascending order with the row strobe alone, so that all rows are covered once per full cycle. A refresh that comes due while an access is in flight waits until that access ends. It is then served before any new request is accepted.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, the row strobe, column strobe and write enable (all active low) are high, the data-bus drive enable is low and the response pulse is low.
- R2: The column strobe is asserted only while the row strobe is low. At a row strobe fall the bus carries the row (request address bits above the column field), and at a column strobe fall it carries the column (the low COL_W request address bits).
- R3: A request whose row equals the open row produces no row strobe fall and is served with a column strobe only.
- R4: A request to a row other than the open row raises the row strobe for a precharge, then lowers it with the new row. This produces exactly one row strobe fall.
- R5: Between a row strobe fall and the next column strobe fall at least T_RCD cycles pass. The column strobe stays low for at least T_CAS cycles, and the row strobe stays high for at least T_RP cycles before each fall.
- R6: A refresh falls due once every REF_INTERVAL cycles. Each refresh is a row strobe low period with no column strobe, and the refreshed rows follow the order 0, 1, 2, ... and wrap after the last row.
- R7: A refresh never begins while an accepted request still waits for its column strobe, and no column strobe or data drive occurs during a refresh.
- R8: A refresh that is pending when the controller is idle is performed before the next request is accepted, so that under continuous traffic the gap between refreshes stays near REF_INTERVAL.
- R9: A request is accepted on a cycle where both valid and ready are high. Each read yields exactly one single-cycle response pulse, and a write yields none.
- R10: A read returns the data most recently written to the same row and column.
- R11: Every row is strobed (by an access or a refresh) at least once within 2^ROW_W × REF_INTERVAL cycles plus a small margin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address: row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The hardest case to reach is a refresh that falls due in the middle of an access and must be held over and then given priority over a request already waiting. It occurs only when the interval counter expires within a few specific cycles of a command sequence. The bench shortens the refresh interval and keeps the request port saturated with back-to-back random traffic that is biased toward a few rows. Collisions with every phase (row, column, precharge, page hit) then happen many times. The behavioural DRAM model measures the gap between refreshes, their row order, their overlap with outstanding requests and the age of every row.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_IDLE = 3'd1,
    ST_ACT  = 3'd2,
    ST_COL  = 3'd3,
    ST_CHI  = 3'd4,
    ST_REF  = 3'd5
  } seq_state_e;

  // Counter load value for a phase that must last 'cycles' clock cycles.
  function automatic int unsigned phase_load(input int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  // Largest of three cycle counts, used to size the phase counter.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Next row in the refresh walk, wrapping at 2**w rows.
  function automatic int unsigned next_row(input int unsigned row, input int unsigned w);
    return (row + 1) % (1 << w);
  endfunction

endpackage

// File: rtl/dpc_refresh_sched.sv
module dpc_refresh_sched
  import dpc_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int REF_INTERVAL = 1563
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack,
  output logic             ref_pending,
  output logic             ref_due,
  output logic [ROW_W-1:0] ref_row
);

  localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [IW-1:0] RELOAD = IW'(phase_load(REF_INTERVAL));

  logic [IW-1:0] ivl_cnt;

  assign ref_due = (ivl_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_cnt     <= RELOAD;
      ref_pending <= 1'b0;
      ref_row     <= '0;
    end else begin
      ivl_cnt <= ref_due ? RELOAD : ivl_cnt - IW'(1);
      if (ref_due)
        ref_pending <= 1'b1;
      else if (ref_ack)
        ref_pending <= 1'b0;
      if (ref_ack)
        ref_row <= ROW_W'(next_row(int'(ref_row), ROW_W));
    end
  end

  // A new due event must never land on a refresh that is still unserved.
  assert_no_lost_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due |-> (!ref_pending || ref_ack))
    else $error("refresh came due while previous one still pending");

  // The sequencer only completes a refresh that was requested.
  assert_ack_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> ref_pending)
    else $error("refresh acknowledged without request");

endmodule

// File: rtl/dpc_cmd_seq.sv
module dpc_cmd_seq
  import dpc_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int A_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ref_pending,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_ack,
  output logic [A_W-1:0]    dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int T_RAS = T_RCD + T_CAS;
  localparam int T_MAX = max3(T_RAS, T_RP, T_CAS);
  localparam int CNT_W = $clog2(T_MAX + 1);

  seq_state_e        state, after_pre;
  logic [CNT_W-1:0]  cnt;
  logic              page_open;
  logic [ROW_W-1:0]  open_row, cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_wdata;

  // Named internal events
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             accept, page_hit, col_done, phase_end, ref_busy;

  assign req_row   = req_addr[ADDR_W-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign page_hit  = page_open && (req_row == open_row);
  assign phase_end = (cnt == '0);
  assign col_done  = (state == ST_COL) && phase_end;
  assign ref_busy  = (state == ST_REF);
  assign ref_ack   = ref_busy && phase_end;

  function automatic logic [CNT_W-1:0] entry_count(input seq_state_e s);
    case (s)
      ST_ACT:  return CNT_W'(phase_load(T_RCD));
      ST_COL:  return CNT_W'(phase_load(T_CAS));
      ST_REF:  return CNT_W'(phase_load(T_RAS));
      ST_PRE:  return CNT_W'(phase_load(T_RP));
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PRE;
      after_pre <= ST_IDLE;
      cnt       <= entry_count(ST_PRE);
      page_open <= 1'b0;
      open_row  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wr    <= 1'b0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= col_done && !cur_wr;
      if (col_done && !cur_wr)
        rsp_rdata <= dram_dq_in;
      case (state)
        ST_PRE: begin
          if (!phase_end) cnt <= cnt - CNT_W'(1);
          else begin
            state <= after_pre;
            cnt   <= entry_count(after_pre);
          end
        end
        ST_IDLE: begin
          if (ref_pending) begin
            if (page_open) begin
              state     <= ST_PRE;
              after_pre <= ST_REF;
              cnt       <= entry_count(ST_PRE);
              page_open <= 1'b0;
            end else begin
              state <= ST_REF;
              cnt   <= entry_count(ST_REF);
            end
          end else if (accept) begin
            cur_row   <= req_row;
            cur_col   <= req_col;
            cur_wr    <= req_write;
            cur_wdata <= req_wdata;
            if (page_hit) begin
              state <= ST_COL;
              cnt   <= entry_count(ST_COL);
            end else if (page_open) begin
              state     <= ST_PRE;
              after_pre <= ST_ACT;
              cnt       <= entry_count(ST_PRE);
              page_open <= 1'b0;
            end else begin
              state <= ST_ACT;
              cnt   <= entry_count(ST_ACT);
            end
          end
        end
        ST_ACT: begin
          if (!phase_end) cnt <= cnt - CNT_W'(1);
          else begin
            state     <= ST_COL;
            cnt       <= entry_count(ST_COL);
            page_open <= 1'b1;
            open_row  <= cur_row;
          end
        end
        ST_COL: begin
          if (!phase_end) cnt <= cnt - CNT_W'(1);
          else state <= ST_CHI;
        end
        ST_CHI: state <= ST_IDLE;
        ST_REF: begin
          if (!phase_end) cnt <= cnt - CNT_W'(1);
          else begin
            state     <= ST_PRE;
            after_pre <= ST_IDLE;
            cnt       <= entry_count(ST_PRE);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobes and bus decoded from the registered state
  always_comb begin
    dram_ras_n  = !((state == ST_ACT) || (state == ST_COL) || (state == ST_CHI) ||
                    ref_busy || ((state == ST_IDLE) && page_open));
    dram_cas_n  = (state != ST_COL);
    dram_we_n   = !((state == ST_COL) && cur_wr);
    dram_dq_oe  = (state == ST_COL) && cur_wr;
    dram_dq_out = cur_wdata;
    case (state)
      ST_ACT:  dram_addr = A_W'(cur_row);
      ST_COL:  dram_addr = A_W'(cur_col);
      ST_REF:  dram_addr = A_W'(ref_row);
      default: dram_addr = A_W'(open_row);
    endcase
  end

  // Strobe run-length counters for the timing assertions
  logic [7:0] ras_hi_run, ras_lo_run, cas_lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_run <= '0;
      ras_lo_run <= '0;
      cas_lo_run <= '0;
    end else begin
      ras_hi_run <= dram_ras_n  ? ((ras_hi_run == 8'hFF) ? ras_hi_run : ras_hi_run + 8'd1) : '0;
      ras_lo_run <= !dram_ras_n ? ((ras_lo_run == 8'hFF) ? ras_lo_run : ras_lo_run + 8'd1) : '0;
      cas_lo_run <= !dram_cas_n ? ((cas_lo_run == 8'hFF) ? cas_lo_run : cas_lo_run + 8'd1) : '0;
    end
  end

  assert_cas_within_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n)
    else $error("column strobe with row strobe high");

  assert_precharge_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_run >= 8'(T_RP)))
    else $error("row strobe high shorter than precharge");

  assert_row_to_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_lo_run >= 8'(T_RCD)))
    else $error("column strobe too soon after row strobe");

  assert_cas_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> (cas_lo_run >= 8'(T_CAS)))
    else $error("column strobe too short");

  assert_refresh_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> (dram_cas_n && !dram_dq_oe))
    else $error("column activity during refresh");

  assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && ref_pending) |=> ((state == ST_REF) || (state == ST_PRE)))
    else $error("pending refresh not started from idle");

  assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle");

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 3,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int REF_INTERVAL = 1563,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int A_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [A_W-1:0]    dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  logic             ref_pending, ref_due, ref_ack;
  logic [ROW_W-1:0] ref_row;

  dpc_refresh_sched #(
    .ROW_W       (ROW_W),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_ack    (ref_ack),
    .ref_pending(ref_pending),
    .ref_due    (ref_due),
    .ref_row    (ref_row)
  );

  dpc_cmd_seq #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .ref_pending(ref_pending),
    .ref_row    (ref_row),
    .ref_ack    (ref_ack),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_dq_out(dram_dq_out),
    .dram_dq_oe (dram_dq_oe),
    .dram_dq_in (dram_dq_in)
  );

  // The refresh walk must not stall: a due event is always answered before the next.
  assert_due_answered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_due && ref_pending) |-> ref_ack)
    else $error("refresh interval expired with refresh outstanding");

endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;

  localparam int RW = 4, CW = 3, DW = 16;
  localparam int TRCD = 2, TCAS = 2, TRP = 3, REFI = 150;
  localparam int ROWS = 1 << RW, COLS = 1 << CW;
  localparam int AW = (RW > CW) ? RW : CW;
  localparam int BUDGET = ROWS * REFI + 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [RW+CW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_out, dq_in;
  logic [AW-1:0] dram_addr;

  always #5 clk = ~clk;

  dram_page_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RCD(TRCD), .T_CAS(TCAS),
                   .T_RP(TRP), .REF_INTERVAL(REFI)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural DRAM ----------------
  logic [DW-1:0] mem    [ROWS*COLS];
  logic [DW-1:0] shadow [ROWS*COLS];
  logic [RW-1:0] row_l = '0;
  bit ras_q = 1'b1, cas_q = 1'b1, cas_seen = 1'b0, busy_at_fall = 1'b0;
  bit pending_access = 1'b0;
  int cyc = 0, rst_cyc = 0, ras_falls = 0, refreshes = 0, exp_ref_row = 0;
  int last_ref_cyc = 0, max_ref_gap = 0, order_err = 0, overlap_err = 0;
  int age_err = 0, cas_outside = 0, hi_run = 0, lo_run = 0, cas_run = 0;
  int min_rp = 1000, min_rcd = 1000, min_cas = 1000;
  int last_act [ROWS];
  logic [RW-1:0] last_fall_row = '0;

  assign dq_in = !cas_n ? mem[{row_l, dram_addr[CW-1:0]}] : '0;

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) begin mem[i] = '0; shadow[i] = '0; end
    for (int r = 0; r < ROWS; r++) last_act[r] = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (ras_q && !ras_n) begin
      row_l = dram_addr[RW-1:0];
      last_fall_row = row_l;
      last_act[row_l] = cyc;
      ras_falls++;
      if (hi_run < min_rp) min_rp = hi_run;
      cas_seen = 1'b0;
      busy_at_fall = pending_access;
    end
    if (!ras_q && ras_n && rst_n) begin
      if (!cas_seen) begin
        if (int'(row_l) != exp_ref_row) order_err++;
        exp_ref_row = (exp_ref_row + 1) % ROWS;
        refreshes++;
        if (cyc - last_ref_cyc > max_ref_gap) max_ref_gap = cyc - last_ref_cyc;
        last_ref_cyc = cyc;
        if (busy_at_fall) overlap_err++;
      end
    end
    if (cas_q && !cas_n) begin
      if (lo_run < min_rcd) min_rcd = lo_run;
      cas_seen = 1'b1;
      pending_access = 1'b0;
    end
    if (!cas_q && cas_n && cas_run < min_cas) min_cas = cas_run;
    if (!cas_n && ras_n) cas_outside++;
    if (!cas_n && !we_n && dq_oe) mem[{row_l, dram_addr[CW-1:0]}] = dq_out;
    if (ras_n) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; end
    if (!cas_n) cas_run++; else cas_run = 0;
    for (int r = 0; r < ROWS; r++) if (cyc - last_act[r] > BUDGET) age_err++;
    ras_q = ras_n;
    cas_q = cas_n;
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] exp_q [$];
  int reads_issued = 0, rsps = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsps++;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected response", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R10 read data", rsp_rdata, e);
      end
    end
  end

  task automatic do_op(input bit wr, input int row, input int col, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {RW'(row), CW'(col)};
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    pending_access = 1'b1;
    if (wr) shadow[{RW'(row), CW'(col)}] = d;
    else begin
      exp_q.push_back(shadow[{RW'(row), CW'(col)}]);
      reads_issued++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int f0, el, e;
    void'($urandom(32'h1a2b));
    repeat (3) @(negedge clk);
    // R1: reset values of strobes, drive enable and response
    chk({ras_n, cas_n, we_n, dq_oe, rsp_valid} == 5'b11100, "R1 reset outputs",
        {ras_n, cas_n, we_n, dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    rst_cyc = cyc;
    last_ref_cyc = cyc;

    // R3: first access opens row 5, following same-row accesses add no row strobe
    do_op(1'b1, 5, 1, 16'hA501);
    wait_quiet();
    f0 = ras_falls;
    do_op(1'b1, 5, 2, 16'hA502);
    do_op(1'b0, 5, 1, 16'h0);
    wait_quiet();
    chk(ras_falls == f0, "R3 page hit row strobes", ras_falls - f0, 0);

    // R4: other row closes the page and opens exactly one new row; R2 row on bus
    f0 = ras_falls;
    do_op(1'b0, 9, 1, 16'h0);
    wait_quiet();
    chk(ras_falls == f0 + 1, "R4 page miss row strobes", ras_falls - f0, 1);
    chk(last_fall_row == 4'd9, "R2 row address at row strobe", last_fall_row, 9);
    do_op(1'b0, 5, 2, 16'h0);
    wait_quiet();

    // R8/R10: saturated random traffic biased toward a few rows
    for (int i = 0; i < 900; i++) begin
      int row;
      row = ($urandom_range(0, 9) < 7) ? $urandom_range(0, 3) : $urandom_range(0, ROWS-1);
      do_op($urandom_range(0, 1) == 1, row, $urandom_range(0, COLS-1), DW'($urandom));
    end
    wait_quiet();
    // R9: writes alone produce no responses
    f0 = rsps;
    for (int i = 0; i < 10; i++) do_op(1'b1, i, i % COLS, DW'(i * 77));
    wait_quiet();
    chk(rsps == f0, "R9 writes give no response", rsps - f0, 0);
    // read back those writes
    for (int i = 0; i < 10; i++) do_op(1'b0, i, i % COLS, 16'h0);
    wait_quiet();

    // R6/R11: idle time, refresh keeps walking
    repeat (3000) @(negedge clk);

    chk(rsps == reads_issued, "R9 one response per read", rsps, reads_issued);
    chk(order_err == 0, "R6 refresh row order", order_err, 0);
    el = cyc - rst_cyc;
    e = el / REFI;
    chk(refreshes >= e - 1 && refreshes <= e, "R6 refresh count", refreshes, e);
    chk(overlap_err == 0, "R7 refresh overlapping access", overlap_err, 0);
    chk(max_ref_gap <= REFI + 24, "R8 refresh gap under traffic", max_ref_gap, REFI + 24);
    chk(age_err == 0, "R11 row age budget", age_err, 0);
    chk(min_rp >= TRP, "R5 precharge width", min_rp, TRP);
    chk(min_rcd >= TRCD, "R5 row to column delay", min_rcd, TRCD);
    chk(min_cas >= TCAS, "R5 column strobe width", min_cas, TCAS);
    chk(cas_outside == 0, "R2 column strobe with row strobe high", cas_outside, 0);
    summary();
    $finish;
  end

endmodule